// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds a physical file of general registers, a multiple of four deep, and presents a 16-register logical window that slides over it in steps of four. The window position (the base) and one frame-start bit per base position are kept here. A processor pipeline drives one window operation per cycle: a call-frame entry, a pre-access check for frames still held by callers, a windowed return, a free rotation, a stack-move check, and a restore of the base saved at the last window exception. The pipeline also supplies the processor state bits that gate these operations. The block answers with a registered result one cycle later.

Logical register `r` of the window lives at physical index `(base*4 + r) mod NAREG`, so the window wraps around the end of the file. When a check or a return finds that a frame must be spilled or refilled, the block moves the base and saves the old base and the PC. It then raises an overflow or underflow exception with a size class of 4, 8 or 12 registers. The pipeline sets its exception-mode bit when it sees that pulse and vectors to the handler. A return takes its call increment from the two top bits of logical register 0 and rebuilds the return PC from those bits.

Top module: `win_regfile_ctrl`

## Requirements
- R1: After reset the base is 0, only frame-start bit 0 is set, the saved base is 0, every result pulse is low and every register reads 0.
- R2: A write or read of logical register r reaches physical entry (base*4 + r) mod NAREG, so data written under one base is found at a shifted logical index after the base moves, including across the wrap.
- R3: Rotate (op_code 4) adds op_rot, taken as a signed 4-bit value, to the base modulo NAREG/4, whatever the processor state bits are.
- R4: Entry (op_code 1) with ps_woe=0, with ps_excm=1, or with op_sreg above 3 pulses illegal and changes no state.
- R5: A legal entry writes a[s] - op_imm*8 into logical register ps_callinc*4 + s of the current window, adds ps_callinc to the base, and sets the frame-start bit at the new base.
- R6: Check (op_code 2) tests the frame-start bits at base+1 up to base+op_wcnt in that order. If none is set, or the state bits do not allow window operations, nothing changes and no exception is raised.
- R7: If check first finds a set bit at base+n, the base moves by n, the old base is saved to ps_owb, op_pc is saved to exc_pc, and exc_valid pulses with exc_under=0. exc_size is 1 (4 registers) if the bit at base+n+1 is set, otherwise 2 (8 registers) if the bit at base+n+2 is set, otherwise 3 (12 registers).
- R8: Return (op_code 3) takes n from a0[31:30] and moves the base back by n. If the frame-start bit at the new base is set, it clears the bit of the old base and pulses ret_valid with ret_pc = {op_pc[31:30], a0[29:0]}.
- R9: Return pulses illegal and changes no state when n is 0, when the state bits forbid window operations, or when the caller size m is nonzero and differs from n. m is 1, 2 or 3 for the nearest set frame-start bit at base-1, base-2 or base-3, and 0 if none of them is set.
- R10: A legal return whose new-base frame-start bit is clear still moves the base. It leaves the frame-start bits unchanged, saves the old base and op_pc, and pulses exc_valid with exc_under=1 and exc_size=n, without ret_valid.
- R11: Stack-move check (op_code 5) pulses alloca only when the frame-start bits at base-1, base-2 and base-3 are all clear, and otherwise changes nothing.
- R12: Restore (op_code 6) loads the base from ps_owb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Window operation strobe |
| op_code | input | 3 | 1 entry, 2 check, 3 return, 4 rotate, 5 stack-move check, 6 restore |
| op_sreg | input | 4 | Stack-pointer register index for entry |
| op_imm | input | IMMW | Frame size for entry, in units of 8 bytes |
| op_wcnt | input | 2 | Number of positions the check searches (0 to 3) |
| op_rot | input | 4 | Signed rotate amount |
| op_pc | input | DW | PC of the operation |
| ps_woe | input | 1 | Window operations enabled |
| ps_excm | input | 1 | Exception mode active |
| ps_callinc | input | 2 | Call increment of the pending entry |
| rf_we | input | 1 | Logical register write strobe |
| rf_waddr | input | 4 | Logical register write index |
| rf_wdata | input | DW | Logical register write data |
| rf_raddr | input | 4 | Logical register read index |
| rf_rdata | output | DW | Logical register read data (combinational) |
| win_base | output | log2(NAREG/4) | Current base |
| win_start | output | NAREG/4 | Frame-start bits |
| ps_owb | output | log2(NAREG/4) | Base saved at the last window exception |
| exc_valid | output | 1 | Window exception pulse |
| exc_under | output | 1 | 1 underflow, 0 overflow |
| exc_size | output | 2 | 1, 2 or 3 for 4, 8 or 12 registers |
| exc_pc | output | DW | PC saved with the exception |
| illegal | output | 1 | Illegal-instruction pulse |
| alloca | output | 1 | Stack-move exception pulse |
| ret_valid | output | 1 | Completed-return pulse |
| ret_pc | output | DW | Return PC of the last completed return |

## Verification
The assertions assume that an external write and an entry do not fall in the same cycle, and that op_code holds one of the six defined codes whenever op_valid is high. They also assume that ps_owb reflects the saved base, which holds because nothing else drives it. The stimulus issues either one external write or one operation per cycle, never both. It draws op_code only from the defined set and keeps the state bits mostly permissive, so that legal paths are hit often. It writes register 0 with random top bits so that returns land in the legal, illegal and underflow cases.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_WCHECK  = 3'd2,
        OP_RETW    = 3'd3,
        OP_ROTW    = 3'd4,
        OP_MOVSP   = 3'd5,
        OP_RESTORE = 3'd6,
        OP_RSVD    = 3'd7
    } wrf_op_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_4    = 2'd1,
        SZ_8    = 2'd2,
        SZ_12   = 2'd3
    } wrf_size_e;

endpackage

// File: rtl/wrf_probe.sv
// Looks up frame-start bits at fixed offsets around the current base.
module wrf_probe #(
    parameter int NWIN = 16,
    parameter int WBW  = 4
) (
    input  logic [NWIN-1:0] ws,
    input  logic [WBW-1:0]  base,
    output logic [5:1]      fwd,
    output logic [3:1]      bwd
);
    for (genvar k = 1; k <= 5; k++) begin : g_fwd
        logic [WBW-1:0] idx;
        assign idx    = base + WBW'(k);
        assign fwd[k] = ws[idx];
    end

    for (genvar k = 1; k <= 3; k++) begin : g_bwd
        logic [WBW-1:0] idx;
        assign idx    = base - WBW'(k);
        assign bwd[k] = ws[idx];
    end
endmodule

// File: rtl/wrf_regfile.sv
// Physical register array with a logical, base-relative addressing view.
module wrf_regfile #(
    parameter int NAREG = 64,
    parameter int DW    = 32,
    parameter int WBW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [WBW-1:0] base,
    input  logic           we,
    input  logic [3:0]     waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [3:0]     raddr_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [3:0]     raddr_b,
    output logic [DW-1:0]  rdata_b
);
    localparam int PAW = WBW + 2;

    logic [DW-1:0]  mem_q [NAREG];
    logic [PAW-1:0] pw, pa, pb;

    assign pw = {base, 2'b00} + PAW'(waddr);
    assign pa = {base, 2'b00} + PAW'(raddr_a);
    assign pb = {base, 2'b00} + PAW'(raddr_b);

    assign rdata_a = mem_q[pa];
    assign rdata_b = mem_q[pb];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NAREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[pw] <= wdata;
        end
    end

    // R2: a write lands at the physical entry selected by the base of its cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(pw)] == $past(wdata));
endmodule

// File: rtl/win_regfile_ctrl.sv
module win_regfile_ctrl
    import wrf_pkg::*;
#(
    parameter int NAREG = 64,
    parameter int DW    = 32,
    parameter int IMMW  = 12,
    localparam int NWIN = NAREG / 4,
    localparam int WBW  = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [3:0]      op_sreg,
    input  logic [IMMW-1:0] op_imm,
    input  logic [1:0]      op_wcnt,
    input  logic [3:0]      op_rot,
    input  logic [DW-1:0]   op_pc,
    input  logic            ps_woe,
    input  logic            ps_excm,
    input  logic [1:0]      ps_callinc,
    input  logic            rf_we,
    input  logic [3:0]      rf_waddr,
    input  logic [DW-1:0]   rf_wdata,
    input  logic [3:0]      rf_raddr,
    output logic [DW-1:0]   rf_rdata,
    output logic [WBW-1:0]  win_base,
    output logic [NWIN-1:0] win_start,
    output logic [WBW-1:0]  ps_owb,
    output logic            exc_valid,
    output logic            exc_under,
    output logic [1:0]      exc_size,
    output logic [DW-1:0]   exc_pc,
    output logic            illegal,
    output logic            alloca,
    output logic            ret_valid,
    output logic [DW-1:0]   ret_pc
);
    typedef struct packed {
        logic [WBW-1:0]  base;
        logic [NWIN-1:0] ws;
        logic [WBW-1:0]  owb;
        logic [DW-1:0]   epc;
        logic [DW-1:0]   retpc;
        logic            exc;
        logic            under;
        logic [1:0]      size;
        logic            ill;
        logic            alloca;
        logic            ret;
    } st_t;

    st_t st_d, st_q;

    wrf_op_e          op;
    logic             legal;
    logic [5:1]       fwd;
    logic [3:1]       bwd;
    logic [1:0]       hit_n;
    logic [1:0]       caller;
    logic [1:0]       ret_n;
    logic [3:0]       rd_b_addr;
    logic [DW-1:0]    rd_b;
    logic             ent_we;
    logic [3:0]       ent_addr;
    logic [DW-1:0]    ent_data;
    logic [WBW+3:0]   rot_ext;
    logic [WBW-1:0]   nxt_base;

    assign op        = wrf_op_e'(op_code);
    assign legal     = ps_woe & ~ps_excm;
    assign rd_b_addr = (op == OP_RETW) ? 4'd0 : op_sreg;
    assign ret_n     = rd_b[DW-1 -: 2];
    assign rot_ext   = {{WBW{op_rot[3]}}, op_rot};
    assign ent_addr  = {ps_callinc, op_sreg[1:0]};
    assign ent_data  = rd_b - (DW'(op_imm) << 3);

    wrf_probe #(.NWIN(NWIN), .WBW(WBW)) u_probe (
        .ws   (st_q.ws),
        .base (st_q.base),
        .fwd  (fwd),
        .bwd  (bwd)
    );

    wrf_regfile #(.NAREG(NAREG), .DW(DW), .WBW(WBW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (st_q.base),
        .we      (ent_we | rf_we),
        .waddr   (ent_we ? ent_addr : rf_waddr),
        .wdata   (ent_we ? ent_data : rf_wdata),
        .raddr_a (rf_raddr),
        .rdata_a (rf_rdata),
        .raddr_b (rd_b_addr),
        .rdata_b (rd_b)
    );

    // nearest caller frame behind the base, and nearest marked frame ahead
    always_comb begin
        caller = bwd[1] ? 2'd1 : bwd[2] ? 2'd2 : bwd[3] ? 2'd3 : 2'd0;
        hit_n  = 2'd0;
        for (int k = 3; k >= 1; k--) begin
            if (k <= int'(op_wcnt) && fwd[k]) hit_n = 2'(k);
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.exc    = 1'b0;
        st_d.under  = 1'b0;
        st_d.size   = SZ_NONE;
        st_d.ill    = 1'b0;
        st_d.alloca = 1'b0;
        st_d.ret    = 1'b0;
        ent_we      = 1'b0;
        nxt_base    = st_q.base;
        if (op_valid) begin
            unique case (op)
                OP_ENTRY: begin
                    if (!legal || op_sreg > 4'd3) begin
                        st_d.ill = 1'b1;
                    end else begin
                        ent_we            = 1'b1;
                        nxt_base          = st_q.base + WBW'(ps_callinc);
                        st_d.base         = nxt_base;
                        st_d.ws[nxt_base] = 1'b1;
                    end
                end
                OP_WCHECK: begin
                    if (legal && hit_n != 2'd0) begin
                        st_d.base  = st_q.base + WBW'(hit_n);
                        st_d.owb   = st_q.base;
                        st_d.epc   = op_pc;
                        st_d.exc   = 1'b1;
                        st_d.under = 1'b0;
                        if (fwd[3'(hit_n) + 3'd1])      st_d.size = SZ_4;
                        else if (fwd[3'(hit_n) + 3'd2]) st_d.size = SZ_8;
                        else                            st_d.size = SZ_12;
                    end
                end
                OP_RETW: begin
                    if (!legal || ret_n == 2'd0 || (caller != 2'd0 && caller != ret_n)) begin
                        st_d.ill = 1'b1;
                    end else begin
                        st_d.base = st_q.base - WBW'(ret_n);
                        if (bwd[ret_n]) begin
                            st_d.ws[st_q.base] = 1'b0;
                            st_d.ret           = 1'b1;
                            st_d.retpc         = {op_pc[DW-1 -: 2], rd_b[DW-3:0]};
                        end else begin
                            st_d.owb   = st_q.base;
                            st_d.epc   = op_pc;
                            st_d.exc   = 1'b1;
                            st_d.under = 1'b1;
                            st_d.size  = ret_n;
                        end
                    end
                end
                OP_ROTW:    st_d.base   = st_q.base + rot_ext[WBW-1:0];
                OP_MOVSP:   st_d.alloca = ~(bwd[1] | bwd[2] | bwd[3]);
                OP_RESTORE: st_d.base   = st_q.owb;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ws <= NWIN'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign win_base  = st_q.base;
    assign win_start = st_q.ws;
    assign ps_owb    = st_q.owb;
    assign exc_valid = st_q.exc;
    assign exc_under = st_q.under;
    assign exc_size  = st_q.size;
    assign exc_pc    = st_q.epc;
    assign illegal   = st_q.ill;
    assign alloca    = st_q.alloca;
    assign ret_valid = st_q.ret;
    assign ret_pc    = st_q.retpc;

    // R4: disabled window state makes entry and return illegal, base untouched
    a_r4_gated_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_ENTRY || op == OP_RETW) && !legal)
        |=> (illegal && $stable(win_base)));

    // R4, R8, R11: at most one outcome per operation
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_valid, illegal, alloca, ret_valid}));

    // R5: a completed entry leaves its new base marked
    a_r5_entry_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ENTRY && legal && op_sreg <= 4'd3)
        |=> win_start[win_base]);

    // R6: an empty search never raises a window exception
    a_r6_no_search: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_WCHECK && op_wcnt == 2'd0) |=> !exc_valid);

    // R7, R10: a window exception saves the base that was current before it
    a_r7_owb_saved: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (ps_owb == $past(win_base)));

    // R12: restore takes the saved base
    a_r12_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_RESTORE) |=> (win_base == $past(ps_owb)));
endmodule

// File: tb/win_regfile_ctrl_tb.sv
module win_regfile_ctrl_tb;
    localparam int NAREG = 64;
    localparam int NWIN  = NAREG / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [3:0]  op_sreg = '0;
    logic [11:0] op_imm = '0;
    logic [1:0]  op_wcnt = '0;
    logic [3:0]  op_rot = '0;
    logic [31:0] op_pc = '0;
    logic        ps_woe = 1'b1;
    logic        ps_excm = 1'b0;
    logic [1:0]  ps_callinc = '0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_waddr = '0;
    logic [31:0] rf_wdata = '0;
    logic [3:0]  rf_raddr = '0;
    logic [31:0] rf_rdata;
    logic [3:0]  win_base;
    logic [15:0] win_start;
    logic [3:0]  ps_owb;
    logic        exc_valid, exc_under, illegal, alloca, ret_valid;
    logic [1:0]  exc_size;
    logic [31:0] exc_pc, ret_pc;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference state
    logic [31:0] phys [NAREG];
    int          m_base, m_owb;
    logic [15:0] m_ws;
    logic [31:0] m_epc, m_retpc;
    bit          e_exc, e_under, e_ill, e_alloca, e_ret;
    int          e_size;

    always #2 clk = ~clk;

    win_regfile_ctrl u_dut (.*);

    function automatic int pidx(int r);
        return (m_base * 4 + r) % NAREG;
    endfunction

    function automatic bit wsb(int off);
        return m_ws[((m_base + off) % NWIN + NWIN) % NWIN];
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "base", win_base, m_base);
        chk(tag, "start", win_start, m_ws);
        chk(tag, "owb", ps_owb, m_owb);
        chk(tag, "exc", exc_valid, e_exc);
        chk(tag, "illegal", illegal, e_ill);
        chk(tag, "alloca", alloca, e_alloca);
        chk(tag, "ret", ret_valid, e_ret);
        if (e_exc) begin
            chk(tag, "under", exc_under, e_under);
            chk(tag, "size", exc_size, e_size);
            chk(tag, "epc", exc_pc, m_epc);
        end
        if (e_ret) chk(tag, "retpc", ret_pc, m_retpc);
        begin
            int r = $urandom_range(0, 15);
            rf_raddr = 4'(r);
            #1;
            chk("R2", "readback", rf_rdata, phys[pidx(r)]);
        end
    endtask

    task automatic clear_exp();
        e_exc = 0; e_under = 0; e_ill = 0; e_alloca = 0; e_ret = 0; e_size = 0;
    endtask

    task automatic wr_reg(int r, logic [31:0] v);
        clear_exp();
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = 4'(r); rf_wdata = v;
        phys[pidx(r)] = v;
        @(negedge clk);
        rf_we = 1'b0;
        compare("R2");
    endtask

    task automatic run_op(int op, int s, int imm, int wc, int rot,
                          logic [31:0] pc, bit woe, bit excm, int ci);
        string tag = "R3";
        bit legal = woe && !excm;
        logic [31:0] a0;
        int n, m, hit, ob, rs;
        clear_exp();
        case (op)
            1: begin
                if (!legal || s > 3) begin
                    e_ill = 1; tag = "R4";
                end else begin
                    tag = "R5";
                    phys[pidx(ci * 4 + s)] = phys[pidx(s)] - (32'(imm) << 3);
                    m_base = (m_base + ci) % NWIN;
                    m_ws[m_base] = 1'b1;
                end
            end
            2: begin
                hit = 0;
                if (legal)
                    for (int k = 1; k <= wc; k++) if (hit == 0 && wsb(k)) hit = k;
                if (hit == 0) tag = "R6";
                else begin
                    tag = "R7";
                    e_size = wsb(hit + 1) ? 1 : (wsb(hit + 2) ? 2 : 3);
                    m_owb = m_base; m_epc = pc;
                    m_base = (m_base + hit) % NWIN;
                    e_exc = 1; e_under = 0;
                end
            end
            3: begin
                a0 = phys[pidx(0)];
                n = int'(a0[31:30]);
                m = wsb(-1) ? 1 : (wsb(-2) ? 2 : (wsb(-3) ? 3 : 0));
                if (!legal || n == 0 || (m != 0 && m != n)) begin
                    e_ill = 1; tag = "R9";
                end else begin
                    ob = m_base;
                    m_base = (m_base - n + NWIN) % NWIN;
                    if (m_ws[m_base]) begin
                        m_ws[ob] = 1'b0; e_ret = 1; tag = "R8";
                        m_retpc = {pc[31:30], a0[29:0]};
                    end else begin
                        m_owb = ob; m_epc = pc; tag = "R10";
                        e_exc = 1; e_under = 1; e_size = n;
                    end
                end
            end
            4: begin
                rs = (rot >= 8) ? rot - 16 : rot;
                m_base = (m_base + rs + NWIN) % NWIN;
                tag = "R3";
            end
            5: begin
                e_alloca = !(wsb(-1) || wsb(-2) || wsb(-3));
                tag = "R11";
            end
            default: begin
                m_base = m_owb;
                tag = "R12";
            end
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'(op); op_sreg = 4'(s); op_imm = 12'(imm);
        op_wcnt = 2'(wc); op_rot = 4'(rot); op_pc = pc;
        ps_woe = woe; ps_excm = excm; ps_callinc = 2'(ci);
        @(negedge clk);
        op_valid = 1'b0;
        compare(tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NAREG; i++) phys[i] = '0;
        m_base = 0; m_owb = 0; m_ws = 16'h0001; m_epc = '0; m_retpc = '0;
        clear_exp();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare("R1");
        chk("R1", "exc_under", exc_under, 0);
        chk("R1", "exc_size", exc_size, 0);

        // directed corners
        wr_reg(0, 32'h4000_1234);
        run_op(3, 0, 0, 0, 0, 32'hC000_0010, 1, 0, 0);   // R10 underflow to base 15
        run_op(6, 0, 0, 0, 0, 32'h0, 1, 0, 0);           // R12 back to 0
        run_op(4, 0, 0, 0, 15, 32'h0, 0, 1, 0);          // R3 -1 wraps
        run_op(4, 0, 0, 0, 1, 32'h0, 0, 1, 0);           // R3 +1 wraps back
        run_op(1, 5, 3, 0, 0, 32'h0, 1, 0, 1);           // R4 s above 3
        run_op(1, 1, 3, 0, 0, 32'h0, 1, 1, 1);           // R4 excm set
        run_op(2, 0, 0, 0, 0, 32'h0, 1, 0, 0);           // R6 empty search
        run_op(5, 0, 0, 0, 0, 32'h0, 1, 0, 0);           // R11 alloca
        wr_reg(1, 32'h0000_1000);
        run_op(1, 1, 2, 0, 0, 32'h0, 1, 0, 1);           // R5 entry to base 1
        run_op(5, 0, 0, 0, 0, 32'h0, 1, 0, 0);           // R11 no alloca
        run_op(4, 0, 0, 0, 14, 32'h0, 1, 0, 0);          // R3 to base 15
        run_op(2, 0, 0, 0, 3, 32'h1234_5678, 1, 0, 0);   // R7 hit at n=1
        run_op(6, 0, 0, 0, 0, 32'h0, 1, 0, 0);           // R12
        run_op(4, 0, 0, 0, 2, 32'h0, 1, 0, 0);           // R3 to base 1
        wr_reg(0, 32'h4000_0100);
        run_op(3, 0, 0, 0, 0, 32'h8000_0000, 1, 0, 0);   // R8 return
        wr_reg(0, 32'h0000_0100);
        run_op(3, 0, 0, 0, 0, 32'h8000_0000, 1, 0, 0);   // R9 n=0

        // constrained random
        for (int it = 0; it < 4000; it++) begin
            int sel = $urandom_range(0, 11);
            bit woe = ($urandom_range(0, 9) != 0);
            bit excm = ($urandom_range(0, 9) == 0);
            if (sel <= 2) begin
                int r = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 15);
                logic [31:0] v = $urandom();
                wr_reg(r, v);
            end else begin
                int op = (sel <= 4) ? 1 : (sel <= 6) ? 3 : (sel == 7) ? 2 :
                         (sel == 8) ? 4 : (sel == 9) ? 5 : (sel == 10) ? 2 : 6;
                run_op(op, $urandom_range(0, 4), $urandom_range(0, 4095),
                       $urandom_range(0, 3), $urandom_range(0, 15), $urandom(),
                       woe, excm, $urandom_range(0, 3));
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule